// File: doc/BRIEF.md
# Per-Line Load-Locked Reservation Tracker

This block sits beside a small cache with a fixed number of lines. It records which execution contexts have done a load-locked access to each line. It also decides whether a store-conditional may write. A context is a pair: a CPU number and a thread number. Each line keeps its own small set of reservations, so several contexts can hold a reservation on the same line at once. Any store to a line clears that line's whole set, whether the store is ordinary or conditional. Invalidating the line clears the set too.

The cache presents one access per cycle. Each access carries a line index, a kind and the requester's context. A separate invalidate strobe may name a line in the same cycle. One cycle after each access, the block returns a response-valid pulse with two bits: a write-permit flag and a store-conditional result. Data storage, tag lookup, coherence and replacement are handled elsewhere.

Top module: `llsc_resv_tracker`

## Requirements
- R1: Synchronous reset, held high, empties every line's reservation set. After reset, `rsp_valid` is low, and a store-conditional to any line fails.
- R2: Each cycle with `acc_valid` high produces exactly one cycle of `rsp_valid` on the following cycle. A cycle without `acc_valid` produces no response.
- R3: A load-locked access (`acc_kind` 2'b00) adds the requester's context to the addressed line's set. Its response has `rsp_permit`=0 and `rsp_sc_ok`=0.
- R4: A store-conditional (`acc_kind` 2'b10) succeeds when some reservation on the line matches both the CPU and the thread number of the requester. Success gives `rsp_sc_ok`=1 and `rsp_permit`=1.
- R5: A store-conditional with no matching reservation responds with `rsp_sc_ok`=0 and `rsp_permit`=0. A reservation that differs only in CPU, or only in thread, does not match.
- R6: Every store-conditional empties the addressed line's set, whether it succeeds or fails.
- R7: An ordinary store (`acc_kind` 2'b01, with 2'b11 treated the same) responds with `rsp_permit`=1 and `rsp_sc_ok`=0, and empties the addressed line's set.
- R8: An invalidate (`inv_valid` with `inv_line`) empties that line's set.
- R9: An invalidate and an access to the same line in one cycle apply the invalidate first. A store-conditional in that cycle fails. A load-locked in that cycle still leaves its new reservation.
- R10: Accesses and invalidates aimed at one line leave every other line's reservations unchanged.
- R11: Each line holds `SLOTS` reservations (default 4). A load-locked to a full line overwrites the oldest reservation. A line that is exactly full loses none.
- R12: Reservations from several contexts coexist on one line. Repeated load-locked accesses from the same context are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_line | input | LINE_W | Line index of the access |
| acc_kind | input | 2 | 00 load-locked, 01 store, 10 store-conditional, 11 store |
| acc_cpu | input | CPU_W | Requester CPU number |
| acc_thr | input | THR_W | Requester thread number |
| inv_valid | input | 1 | Line-invalidate strobe |
| inv_line | input | LINE_W | Line index to invalidate |
| rsp_valid | output | 1 | Response pulse, one cycle after the access |
| rsp_permit | output | 1 | The write may proceed |
| rsp_sc_ok | output | 1 | Store-conditional result |

## Verification
The assertions assume that `acc_line` and `inv_line` name existing lines whenever their strobes are high. They also assume that inputs are steady around the rising edge. The bench drives every input on the falling edge. It uses only the default eight lines, with indices 0 to 7. The reservation state is never read directly: every expected value is observed through store-conditional results. Each fill, overwrite and clear scenario therefore ends with a conditional store whose outcome the bench predicts.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  localparam logic [1:0] KIND_LL     = 2'b00;
  localparam logic [1:0] KIND_ST     = 2'b01;
  localparam logic [1:0] KIND_SC     = 2'b10;
  localparam logic [1:0] KIND_ST_ALT = 2'b11;
endpackage

// File: rtl/llsc_line.sv
module llsc_line #(
  parameter int SLOTS = 4,
  parameter int CPU_W = 2,
  parameter int THR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             inv_hit,
  input  logic [1:0]       kind,
  input  logic [CPU_W-1:0] cpu,
  input  logic [THR_W-1:0] thr,
  output logic             match
);
  import llsc_pkg::*;

  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] slot_vld, vld_nxt;
  logic [PTR_W-1:0] ptr, ptr_nxt, wptr;
  logic [CPU_W-1:0] slot_cpu [SLOTS];
  logic [THR_W-1:0] slot_thr [SLOTS];
  logic [SLOTS-1:0] eq;
  logic             is_ll;

  assign is_ll = hit && (kind == KIND_LL);

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    assign eq[s] = slot_vld[s] && (slot_cpu[s] == cpu) && (slot_thr[s] == thr);
  end

  // The invalidate is applied first, so it hides any reservation.
  assign match = (|eq) && !inv_hit;

  always_comb begin
    vld_nxt = slot_vld;
    ptr_nxt = ptr;
    if (inv_hit || (hit && kind != KIND_LL)) begin
      vld_nxt = '0;
      ptr_nxt = '0;
    end
    wptr = inv_hit ? '0 : ptr;
    if (is_ll) begin
      vld_nxt[wptr] = 1'b1;
      ptr_nxt = (wptr == PTR_W'(SLOTS - 1)) ? '0 : wptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld <= '0;
      ptr      <= '0;
    end else begin
      slot_vld <= vld_nxt;
      ptr      <= ptr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (is_ll) begin
      slot_cpu[wptr] <= cpu;
      slot_thr[wptr] <= thr;
    end
  end

  p_ll_sets_r3: assert property (@(posedge clk) disable iff (rst)
    is_ll |=> slot_vld != '0);
  p_store_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (hit && kind != KIND_LL) |=> slot_vld == '0);
  p_inv_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (inv_hit && !hit) |=> slot_vld == '0);
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (!hit && !inv_hit) |=> $stable(slot_vld));
  p_fill_grows_r11: assert property (@(posedge clk) disable iff (rst)
    (is_ll && !inv_hit && $countones(slot_vld) < SLOTS)
      |=> $countones(slot_vld) == $past($countones(slot_vld)) + 1);
endmodule

// File: rtl/llsc_resp.sv
module llsc_resp (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_valid,
  input  logic [1:0] acc_kind,
  input  logic       sel_match,
  output logic       rsp_valid,
  output logic       rsp_permit,
  output logic       rsp_sc_ok
);
  import llsc_pkg::*;

  logic is_sc, is_st;
  assign is_sc = (acc_kind == KIND_SC);
  assign is_st = (acc_kind == KIND_ST) || (acc_kind == KIND_ST_ALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_permit <= 1'b0;
      rsp_sc_ok  <= 1'b0;
    end else begin
      rsp_valid  <= acc_valid;
      rsp_permit <= acc_valid && (is_st || (is_sc && sel_match));
      rsp_sc_ok  <= acc_valid && is_sc && sel_match;
    end
  end

  p_ok_needs_permit_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_sc_ok |-> (rsp_permit && rsp_valid));
  p_ok_only_sc_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !is_sc) |=> !rsp_sc_ok);
endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker #(
  parameter int NUM_LINES = 8,
  parameter int SLOTS     = 4,
  parameter int CPU_W     = 2,
  parameter int THR_W     = 2,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [LINE_W-1:0] acc_line,
  input  logic [1:0]        acc_kind,
  input  logic [CPU_W-1:0]  acc_cpu,
  input  logic [THR_W-1:0]  acc_thr,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              rsp_valid,
  output logic              rsp_permit,
  output logic              rsp_sc_ok
);
  import llsc_pkg::*;

  logic [NUM_LINES-1:0] hit, inv_hit, match;
  logic                 sel_match;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign hit[l]     = acc_valid && (acc_line == LINE_W'(l));
    assign inv_hit[l] = inv_valid && (inv_line == LINE_W'(l));
    llsc_line #(.SLOTS(SLOTS), .CPU_W(CPU_W), .THR_W(THR_W)) u_line (
      .clk(clk), .rst(rst), .hit(hit[l]), .inv_hit(inv_hit[l]),
      .kind(acc_kind), .cpu(acc_cpu), .thr(acc_thr), .match(match[l])
    );
  end

  assign sel_match = |(match & hit);

  llsc_resp u_resp (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .sel_match(sel_match), .rsp_valid(rsp_valid), .rsp_permit(rsp_permit),
    .rsp_sc_ok(rsp_sc_ok)
  );

  p_one_hot_hit_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
  p_inv_first_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && inv_valid && acc_line == inv_line && acc_kind == KIND_SC)
      |=> (rsp_valid && !rsp_sc_ok && !rsp_permit));
  p_no_resp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rsp_valid);
endmodule

// File: tb/tb_llsc_resv_tracker.sv
`timescale 1ns/1ps
module tb_llsc_resv_tracker;
  typedef struct packed {
    logic       inv;
    logic [2:0] iline;
    logic       av;
    logic [2:0] line;
    logic [1:0] kind;
    logic [1:0] cpu;
    logic [1:0] thr;
    logic       ev;
    logic       ep;
    logic       eo;
    logic [7:0] req;
  } vec_t;

  function automatic vec_t v(input logic inv, input int il, input logic av,
      input int ln, input int k, input int c, input int t,
      input logic ev, input logic ep, input logic eo, input int r);
    vec_t x;
    x.inv = inv; x.iline = 3'(il); x.av = av; x.line = 3'(ln);
    x.kind = 2'(k); x.cpu = 2'(c); x.thr = 2'(t);
    x.ev = ev; x.ep = ep; x.eo = eo; x.req = 8'(r);
    return x;
  endfunction

  localparam int NV = 53;
  // fields: inv, inv_line, valid, line, kind, cpu, thr, exp valid/permit/ok, requirement
  localparam vec_t TBL [NV] = '{
    v(0,0,1,0,2,0,0,1,0,0,1),   // R1 empty after reset
    v(0,0,1,3,0,1,2,1,0,0,3),   // R3 load-locked
    v(0,0,1,3,2,1,2,1,1,1,4),   // R4 match
    v(0,0,1,3,2,1,2,1,0,0,6),   // R6 cleared by success
    v(0,0,1,3,0,1,2,1,0,0,3),
    v(0,0,1,3,2,1,3,1,0,0,5),   // R5 thread differs
    v(0,0,1,3,2,1,2,1,0,0,6),   // R6 cleared by failure
    v(0,0,1,3,0,1,2,1,0,0,3),
    v(0,0,1,3,2,3,2,1,0,0,5),   // R5 cpu differs
    v(0,0,1,3,0,1,2,1,0,0,12),
    v(0,0,1,3,0,2,2,1,0,0,12),
    v(0,0,1,3,0,2,2,1,0,0,12),  // R12 duplicate
    v(0,0,1,3,2,1,2,1,1,1,12),  // R12 coexist
    v(0,0,1,3,0,1,2,1,0,0,3),
    v(0,0,1,3,1,0,0,1,1,0,7),   // R7 store
    v(0,0,1,3,2,1,2,1,0,0,7),
    v(0,0,1,3,0,1,2,1,0,0,3),
    v(0,0,1,3,3,0,0,1,1,0,7),   // R7 kind 11
    v(0,0,1,3,2,1,2,1,0,0,7),
    v(0,0,1,3,0,1,2,1,0,0,3),
    v(0,0,1,4,1,0,0,1,1,0,10),
    v(0,0,1,4,0,0,1,1,0,0,3),
    v(0,0,1,4,2,0,1,1,1,1,10),
    v(0,0,1,3,2,1,2,1,1,1,10),  // R10 line 3 survived
    v(0,0,0,0,0,0,0,0,0,0,2),   // R2 idle
    v(0,0,1,5,0,3,3,1,0,0,3),
    v(1,5,0,0,0,0,0,0,0,0,8),
    v(0,0,1,5,2,3,3,1,0,0,8),   // R8
    v(0,0,1,5,0,3,3,1,0,0,3),
    v(1,6,0,0,0,0,0,0,0,0,10),
    v(0,0,1,5,2,3,3,1,1,1,10),
    v(0,0,1,5,0,3,3,1,0,0,3),
    v(1,5,1,5,2,3,3,1,0,0,9),   // R9 same-cycle SC fails
    v(0,0,1,5,2,3,3,1,0,0,9),
    v(1,5,1,5,0,3,3,1,0,0,9),
    v(0,0,1,5,2,3,3,1,1,1,9),   // R9 LL survives
    v(0,0,1,2,0,0,0,1,0,0,11),
    v(0,0,1,2,0,0,1,1,0,0,11),
    v(0,0,1,2,0,1,0,1,0,0,11),
    v(0,0,1,2,0,1,1,1,0,0,11),
    v(0,0,1,2,0,2,0,1,0,0,11),
    v(0,0,1,2,2,0,0,1,0,0,11),  // R11 oldest overwritten
    v(0,0,1,2,0,0,0,1,0,0,11),
    v(0,0,1,2,0,0,1,1,0,0,11),
    v(0,0,1,2,0,1,0,1,0,0,11),
    v(0,0,1,2,0,1,1,1,0,0,11),
    v(0,0,1,2,0,2,0,1,0,0,11),
    v(0,0,1,2,2,0,1,1,1,1,11),  // R11 second oldest kept
    v(0,0,1,2,0,0,0,1,0,0,11),
    v(0,0,1,2,0,0,1,1,0,0,11),
    v(0,0,1,2,0,1,0,1,0,0,11),
    v(0,0,1,2,0,1,1,1,0,0,11),
    v(0,0,1,2,2,0,0,1,1,1,11)   // R11 full, none lost
  };

  logic clk = 1'b0, rst = 1'b1;
  logic acc_valid = 1'b0, inv_valid = 1'b0;
  logic [2:0] acc_line = '0, inv_line = '0;
  logic [1:0] acc_kind = '0, acc_cpu = '0, acc_thr = '0;
  logic rsp_valid, rsp_permit, rsp_sc_ok;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  llsc_resv_tracker dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_line(acc_line),
    .acc_kind(acc_kind), .acc_cpu(acc_cpu), .acc_thr(acc_thr),
    .inv_valid(inv_valid), .inv_line(inv_line), .rsp_valid(rsp_valid),
    .rsp_permit(rsp_permit), .rsp_sc_ok(rsp_sc_ok)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t x);
    inv_valid = x.inv; inv_line = x.iline; acc_valid = x.av; acc_line = x.line;
    acc_kind = x.kind; acc_cpu = x.cpu; acc_thr = x.thr;
    @(negedge clk);
    acc_valid = 1'b0; inv_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", rsp_valid, 1'b0);
    for (int i = 0; i < NV; i++) begin
      string r;
      drive(TBL[i]);
      r = $sformatf("R%0d row %0d", TBL[i].req, i);
      chk(r, "rsp_valid", rsp_valid, TBL[i].ev);
      if (TBL[i].ev) begin
        chk(r, "rsp_permit", rsp_permit, TBL[i].ep);
        chk(r, "rsp_sc_ok", rsp_sc_ok, TBL[i].eo);
      end
    end
    // R1: reset in mid-run wipes a live reservation
    drive(v(0,0,1,1,0,0,0,1,0,0,1));
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "rsp_valid during reset", rsp_valid, 1'b0);
    drive(v(0,0,1,1,2,0,0,1,0,0,1));
    chk("R1", "rsp_valid", rsp_valid, 1'b1);
    chk("R1", "rsp_sc_ok after reset", rsp_sc_ok, 1'b0);
    // R2: response lasts exactly one cycle
    @(negedge clk);
    chk("R2", "rsp_valid pulse width", rsp_valid, 1'b0);
    finish_run();
  end
endmodule